// File: doc/BRIEF.md
# Self-Recovering LFSR Noise Generator

This block produces a pseudo-random noise bit stream from a 24-stage Fibonacci linear feedback shift register. The feedback is the XOR of the stages named by the polynomial x^24 + x^23 + x^22 + x^17 + 1, which is primitive. Every non-zero state therefore lies on one cycle of 2^24 - 1 states. Pure XOR feedback maps the all-zero state onto itself, so a wide NOR of all stages flags that state and is ORed into the bit entering the first stage. The register therefore leaves the trap on the next enabled clock. For scrambling, an external random bit (for example a sampled analog comparator) can be XORed into the feedback while a control input allows it.

Each clock, a small controller picks one named step: STEP_RESET (synchronous reset loads the seed 24'h000001), STEP_LOAD (a software-free parallel seed load, any value including zero), STEP_HOLD (enable low, nothing moves), STEP_SHIFT (normal enabled advance) and STEP_ESCAPE (enabled advance out of the all-zero state). The priority is reset, then load, then enable, then the zero test. The serial output is the last stage, and the whole register is also presented in parallel. Stage n of the polynomial is bit n-1 of the parallel output. A shift moves bit i to bit i+1 and the feedback enters bit 0.

Top module: `lfsr_noise_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge the register becomes 24'h000001 (STEP_RESET), whatever the other inputs are.
- R2: With `rst` and `load` low and `en` low, the register keeps its value (STEP_HOLD), including the all-zero value, and `noise_in` has no effect.
- R3: With `en` high, `inject_en` low and a non-zero register, the next register value is {state[22:0], f}, where f = state[23] ^ state[22] ^ state[21] ^ state[16] (STEP_SHIFT).
- R4: With `en` high and the register all zero, the next value is 24'h000001 regardless of `inject_en` and `noise_in` (STEP_ESCAPE).
- R5: With `en` and `inject_en` high, the bit shifted into bit 0 is the tap XOR of R3 further XORed with `noise_in`, ORed with the all-zero flag.
- R6: With `inject_en` low, `noise_in` does not change the sequence.
- R7: With `rst` low and `load` high, the register takes `load_value` at the clock edge, whether `en` is high or low (STEP_LOAD).
- R8: With injection off and a primitive tap set, the register visits 2^WIDTH - 1 distinct states before returning to its seed; this is shown on an 8-stage build with taps at stages 8, 6, 5 and 4 (period 255).
- R9: `noise_bit` always equals bit WIDTH-1 of `state_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset to the seed, highest priority |
| en | input | 1 | Clock enable for shifting |
| inject_en | input | 1 | Allows `noise_in` into the feedback |
| noise_in | input | 1 | External random bit |
| load | input | 1 | Parallel seed load strobe |
| load_value | input | WIDTH (24) | Value taken on a load |
| noise_bit | output | 1 | Serial noise output, last stage |
| state_out | output | WIDTH (24) | Parallel register contents |

## Verification
On every cycle the assertions check that a hold keeps the register stable, that a load lands the requested value, that an ordinary shift moves each bit up one place, that an escape step lands exactly on 24'h000001, and that reset gives the seed. The exact tap XOR, the effect of the injected bit and the blindness to `noise_in` while injection is off are shown only by the bench's per-clock comparison against its behavioural model. The full-period property of R8 is also shown only by the bench, by walking a reduced 8-stage build through its whole cycle.

// File: rtl/lfsr_noise_pkg.sv
package lfsr_noise_pkg;

    // Kind of update the register performs on the coming clock edge.
    typedef enum logic [2:0] {
        STEP_RESET  = 3'd0,
        STEP_LOAD   = 3'd1,
        STEP_HOLD   = 3'd2,
        STEP_SHIFT  = 3'd3,
        STEP_ESCAPE = 3'd4
    } step_kind_e;

    // Default geometry: 24 stages, taps at stages 24, 23, 22 and 17.
    localparam int unsigned DEF_WIDTH = 24;
    localparam logic [DEF_WIDTH-1:0] DEF_TAPS = 24'hE1_0000;
    localparam logic [DEF_WIDTH-1:0] DEF_SEED = 24'h00_0001;

endpackage

// File: rtl/lfsr_zero_detect.sv
module lfsr_zero_detect #(
    parameter int unsigned WIDTH = 24,
    parameter int unsigned CHUNK = 6
) (
    input  logic [WIDTH-1:0] state,
    output logic             all_zero
);
    localparam int unsigned NUM_CHUNKS = (WIDTH + CHUNK - 1) / CHUNK;
    localparam int unsigned PAD_W      = NUM_CHUNKS * CHUNK;

    logic [PAD_W-1:0]      padded;
    logic [NUM_CHUNKS-1:0] chunk_any;

    assign padded = PAD_W'(state);

    // First level: OR inside each chunk; second level: NOR across chunks.
    for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
        assign chunk_any[c] = |padded[c*CHUNK +: CHUNK];
    end

    assign all_zero = ~(|chunk_any);

endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
    parameter int unsigned     WIDTH    = 24,
    parameter logic [WIDTH-1:0] TAP_MASK = 24'hE1_0000
) (
    input  logic [WIDTH-1:0] state,
    input  logic             all_zero,
    input  logic             inject_en,
    input  logic             noise_in,
    output logic             shift_in
);
    logic [WIDTH-1:0] tapped;
    logic             linear_fb;
    logic             mixed_fb;

    for (genvar g = 0; g < WIDTH; g++) begin : g_tap
        if (TAP_MASK[g]) begin : g_on
            assign tapped[g] = state[g];
        end else begin : g_off
            assign tapped[g] = 1'b0;
        end
    end

    assign linear_fb = ^tapped;
    assign mixed_fb  = linear_fb ^ (inject_en & noise_in);
    // Non-linear escape: the zero flag forces a one into stage one.
    assign shift_in  = mixed_fb | all_zero;

endmodule

// File: rtl/lfsr_step_ctrl.sv
module lfsr_step_ctrl
    import lfsr_noise_pkg::*;
(
    input  logic       rst,
    input  logic       load,
    input  logic       en,
    input  logic       all_zero,
    output step_kind_e step
);
    always_comb begin
        if (rst) begin
            step = STEP_RESET;
        end else if (load) begin
            step = STEP_LOAD;
        end else if (!en) begin
            step = STEP_HOLD;
        end else if (all_zero) begin
            step = STEP_ESCAPE;
        end else begin
            step = STEP_SHIFT;
        end
    end

endmodule

// File: rtl/lfsr_shift_core.sv
module lfsr_shift_core
    import lfsr_noise_pkg::*;
#(
    parameter int unsigned      WIDTH = 24,
    parameter logic [WIDTH-1:0] SEED  = 24'h00_0001
) (
    input  logic             clk,
    input  logic             rst,
    input  step_kind_e       step,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] load_value,
    output logic [WIDTH-1:0] state_q
);
    logic [WIDTH-1:0] state_d;

    always_comb begin
        unique case (step)
            STEP_RESET:  state_d = SEED;
            STEP_LOAD:   state_d = load_value;
            STEP_HOLD:   state_d = state_q;
            STEP_SHIFT:  state_d = {state_q[WIDTH-2:0], shift_in};
            STEP_ESCAPE: state_d = {state_q[WIDTH-2:0], shift_in};
            default:     state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // ---- assertions ----
    logic rst_seen_q;
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    always @(posedge clk) begin
        if (rst_seen_q) begin
            a_reset_seed_r1: assert (state_q == SEED)
                else $error("R1: register not at seed after reset");
        end
    end

    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_HOLD) |=> $stable(state_q))
        else $error("R2: register moved during hold");

    p_shift_moves_r3: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_SHIFT) |=> (state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0])))
        else $error("R3: shift did not move bits up");

    p_escape_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_ESCAPE) |=> (state_q == WIDTH'(1)))
        else $error("R4: escape did not land on one");

    p_load_lands_r7: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_LOAD) |=> (state_q == $past(load_value)))
        else $error("R7: load value not taken");

endmodule

// File: rtl/lfsr_noise_gen.sv
module lfsr_noise_gen
    import lfsr_noise_pkg::*;
#(
    parameter int unsigned      WIDTH     = DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAP_MASK  = DEF_TAPS,
    parameter logic [WIDTH-1:0] SEED      = DEF_SEED,
    parameter int unsigned      NOR_CHUNK = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             inject_en,
    input  logic             noise_in,
    input  logic             load,
    input  logic [WIDTH-1:0] load_value,
    output logic             noise_bit,
    output logic [WIDTH-1:0] state_out
);
    logic [WIDTH-1:0] state_q;
    logic             all_zero;
    logic             shift_in;
    step_kind_e       step;

    lfsr_zero_detect #(
        .WIDTH (WIDTH),
        .CHUNK (NOR_CHUNK)
    ) u_zero (
        .state    (state_q),
        .all_zero (all_zero)
    );

    lfsr_feedback #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAP_MASK)
    ) u_fb (
        .state     (state_q),
        .all_zero  (all_zero),
        .inject_en (inject_en),
        .noise_in  (noise_in),
        .shift_in  (shift_in)
    );

    lfsr_step_ctrl u_ctrl (
        .rst      (rst),
        .load     (load),
        .en       (en),
        .all_zero (all_zero),
        .step     (step)
    );

    lfsr_shift_core #(
        .WIDTH (WIDTH),
        .SEED  (SEED)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .shift_in   (shift_in),
        .load_value (load_value),
        .state_q    (state_q)
    );

    assign state_out = state_q;
    assign noise_bit = state_q[WIDTH-1];

endmodule

// File: tb/lfsr_noise_gen_tb.sv
module lfsr_noise_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 24;
    localparam int SW = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic         rst, en, inject_en, noise_in, load;
    logic [W-1:0] load_value;
    logic         noise_bit;
    logic [W-1:0] state_out;

    logic          s_rst, s_en, s_inj, s_noise, s_load;
    logic [SW-1:0] s_lv;
    logic          s_bit;
    logic [SW-1:0] s_state;

    lfsr_noise_gen u_dut (
        .clk(clk), .rst(rst), .en(en), .inject_en(inject_en),
        .noise_in(noise_in), .load(load), .load_value(load_value),
        .noise_bit(noise_bit), .state_out(state_out)
    );

    lfsr_noise_gen #(
        .WIDTH(SW), .TAP_MASK(8'hB8), .SEED(8'h01), .NOR_CHUNK(3)
    ) u_small (
        .clk(clk), .rst(s_rst), .en(s_en), .inject_en(s_inj),
        .noise_in(s_noise), .load(s_load), .load_value(s_lv),
        .noise_bit(s_bit), .state_out(s_state)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    logic [W-1:0] ref_state;
    int tap_list [4] = '{24, 23, 22, 17};

    function automatic logic [W-1:0] model_next(logic [W-1:0] s);
        logic f;
        if (rst) return 24'h000001;
        if (load) return load_value;
        if (!en) return s;
        f = 1'b0;
        foreach (tap_list[k]) f = f ^ s[tap_list[k]-1];
        if (inject_en) f = f ^ noise_in;
        if (s == 0) f = 1'b1;
        return {s[W-2:0], f};
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: model advances, DUT compared at the following falling edge.
    task automatic tick(input string req);
        logic [W-1:0] nxt;
        nxt = model_next(ref_state);
        @(posedge clk);
        @(negedge clk);
        ref_state = nxt;
        check(state_out === ref_state, req, state_out, ref_state);
        check(noise_bit === ref_state[W-1], "R9", {23'd0, noise_bit}, {23'd0, ref_state[W-1]});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int first_return;
        int distinct;
        bit seen [256];
        rst = 1; en = 1; inject_en = 1; noise_in = 1; load = 0; load_value = '1;
        s_rst = 1; s_en = 0; s_inj = 0; s_noise = 0; s_load = 0; s_lv = '0;
        ref_state = '0;
        @(negedge clk);
        // R1: reset with other inputs active
        tick("R1");
        tick("R1");
        check(state_out === 24'h000001, "R1", state_out, 24'h000001);
        rst = 0; inject_en = 0; noise_in = 0;

        // R3: plain enabled shifting
        for (int i = 0; i < 300; i++) tick("R3");

        // R2: hold with noise toggling
        en = 0;
        for (int i = 0; i < 10; i++) begin
            noise_in = i[0];
            inject_en = i[1];
            tick("R2");
        end
        en = 1;

        // R5: injection on with a pattern
        inject_en = 1;
        for (int i = 0; i < 200; i++) begin
            noise_in = ((i * 7) % 5) < 2;
            tick("R5");
        end

        // R6: injection off, noise toggling ignored
        inject_en = 0;
        for (int i = 0; i < 100; i++) begin
            noise_in = ~noise_in;
            tick("R6");
        end

        // R7: load with enable high and low
        load = 1; load_value = 24'hA5C3F0; en = 1;
        tick("R7");
        check(state_out === 24'hA5C3F0, "R7", state_out, 24'hA5C3F0);
        load_value = 24'h123456; en = 0;
        tick("R7");
        load = 0; en = 1;
        for (int i = 0; i < 20; i++) tick("R3");

        // R2: all-zero held while disabled
        load = 1; load_value = '0;
        tick("R7");
        load = 0; en = 0;
        for (int i = 0; i < 3; i++) tick("R2");
        check(state_out === 24'h0, "R2", state_out, 24'h0);

        // R4: escape from zero, injection off
        en = 1;
        tick("R4");
        check(state_out === 24'h000001, "R4", state_out, 24'h000001);

        // R4: escape from zero with injection on and noise high
        load = 1; load_value = '0;
        tick("R7");
        load = 0; inject_en = 1; noise_in = 1;
        tick("R4");
        check(state_out === 24'h000001, "R4", state_out, 24'h000001);
        inject_en = 0; noise_in = 0;
        for (int i = 0; i < 10; i++) tick("R3");

        // R8: full period of the 8-stage build
        @(negedge clk);
        s_rst = 0; s_en = 1;
        for (int k = 0; k < 256; k++) seen[k] = 0;
        check(s_state === 8'h01, "R8", {16'd0, s_state}, 24'h1);
        seen[1] = 1;
        distinct = 1;
        first_return = 0;
        for (int i = 1; i <= 300 && first_return == 0; i++) begin
            @(negedge clk);
            if (s_state == 8'h01) first_return = i;
            else if (!seen[s_state]) begin
                seen[s_state] = 1;
                distinct++;
            end
        end
        check(first_return == 255, "R8", W'(first_return), W'(255));
        check(distinct == 255, "R8", W'(distinct), W'(255));
        finish_run();
    end

endmodule